// File: doc/BRIEF.md
# Threshold-Terminated Accumulator

This block replaces a loop whose trip count depends on its own data with an explicit three-state machine. After a start pulse it clears a running total and then, on every clock edge it spends in its working state, adds the sample present on its data input to that total. The work ends on the edge where the newly formed total rises strictly above a fixed limit (42 by default). It then raises a completion pulse for one cycle and returns to idle, keeping the final total on its output.

The addition is the plain width of the total and wraps around. Inputs can be small or zero, so the total might never pass the limit. An iteration counter therefore forces an exit after a bounded number of additions (255 by default), and every run ends. A caller pulses the start input while the block is idle, waits for the done pulse, and reads the total.

Top module: `thresh_accum`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the total reads 0 and both busy and done read 0.
- R2: A start pulse sampled in idle makes busy read 1 and the total read 0 in the following cycle.
- R3: On every edge in the working state, the total becomes the old total plus the input sample, modulo 256.
- R4: The working state ends on the edge where the updated total exceeds 42. In the next cycle done reads 1 while busy still reads 1.
- R5: An updated total equal to exactly 42 does not end the run. Busy stays 1 and done stays 0.
- R6: When the total never exceeds 42, the run ends after exactly 255 additions.
- R7: Done stays high for exactly one cycle. In the next cycle busy and done both read 0 and the total keeps its final value.
- R8: A start pulse while busy reads 1 has no effect. The run continues and the total is not cleared.
- R9: While idle, or in the done cycle, the input sample has no effect on the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; honoured only when idle |
| din | input | 8 | Sample added on each working edge |
| sum | output | 8 | Running total, held after completion |
| busy | output | 1 | High in the working state and the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check several properties on every cycle:
- each working edge adds exactly the sampled input;
- the total is frozen outside the working state;
- done lasts one cycle and is followed by idle;
- every entry into done is caused by either the limit or the iteration cap;
- a start pulse is never honoured while busy.

Only the bench scenarios can show the following:
- that the first crossing of the limit ends the run, and not a later edge;
- that a total of exactly 42 continues;
- that a wrapped sum which lands below the limit keeps the run going;
- that a stream of zeros ends after precisely 255 additions.

// File: rtl/thresh_accum_pkg.sv
package thresh_accum_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_DONE  = 2'd2
   } acc_state_e;
endpackage

// File: rtl/ta_datapath.sv
module ta_datapath #(
   parameter int DATA_W = 8,
   parameter int LIMIT  = 42
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              acc_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] sum_q,
   output logic              over_lim
);
   localparam logic [DATA_W-1:0] LIM_V = DATA_W'(LIMIT);

   logic [DATA_W-1:0] sum_nxt;

   // wrapping add of the current sample
   always_comb begin
      sum_nxt  = sum_q + din;
      over_lim = (sum_nxt > LIM_V);
   end

   always_ff @(posedge clk) begin
      if (rst)         sum_q <= '0;
      else if (load)   sum_q <= '0;
      else if (acc_en) sum_q <= sum_nxt;
   end

   // R3
   add_step_chk: assert property (@(posedge clk) disable iff (rst)
      acc_en && !load |=> sum_q == DATA_W'($past(sum_q) + $past(din)));
   // R9
   sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load && !acc_en |=> $stable(sum_q));
endmodule

// File: rtl/ta_iter_count.sv
module ta_iter_count #(
   parameter int MAX_ITER = 255,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q,
   output logic             cap_hit
);
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_ITER - 1);

   // the pending step is the final permitted addition
   always_comb cap_hit = step && (cnt_q == LAST_V);

   always_ff @(posedge clk) begin
      if (rst || clear) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;
   end

   // R6
   iter_room_chk: assert property (@(posedge clk) disable iff (rst)
      step |-> cnt_q < CNT_W'(MAX_ITER));
endmodule

// File: rtl/ta_ctrl.sv
module ta_ctrl
   import thresh_accum_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       over_lim,
   input  logic       cap_hit,
   output acc_state_e state_q,
   output logic       load,
   output logic       acc_en
);
   acc_state_e state_d;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      acc_en  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               load    = 1'b1;
               state_d = ST_ACCUM;
            end
         end
         ST_ACCUM: begin
            acc_en = 1'b1;
            if (over_lim || cap_hit) state_d = ST_DONE;
         end
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   // R7
   done_len_chk: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/thresh_accum.sv
module thresh_accum
   import thresh_accum_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LIMIT    = 42,
   parameter int MAX_ITER = 255
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] sum,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = $clog2(MAX_ITER + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("thresh_accum: DATA_W must be at least 2");
      end
      if (LIMIT < 0 || LIMIT >= (1 << DATA_W) - 1) begin : g_bad_limit
         $error("thresh_accum: LIMIT must fit below the largest total");
      end
      if (MAX_ITER < 1) begin : g_bad_iter
         $error("thresh_accum: MAX_ITER must be at least 1");
      end
   endgenerate

   acc_state_e       state_q;
   logic             load, acc_en, over_lim, cap_hit;
   logic [CNT_W-1:0] iter_q;

   ta_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .over_lim (over_lim),
      .cap_hit  (cap_hit),
      .state_q  (state_q),
      .load     (load),
      .acc_en   (acc_en)
   );

   ta_datapath #(.DATA_W(DATA_W), .LIMIT(LIMIT)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .acc_en   (acc_en),
      .din      (din),
      .sum_q    (sum),
      .over_lim (over_lim)
   );

   ta_iter_count #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clear   (load),
      .step    (acc_en),
      .cnt_q   (iter_q),
      .cap_hit (cap_hit)
   );

   always_comb begin
      busy = (state_q != ST_IDLE);
      done = (state_q == ST_DONE);
   end

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (rst)
      !busy && start |=> busy && sum == '0);
   // R8
   start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      busy && !done |=> busy);
   // R4
   done_cause_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (sum > DATA_W'(LIMIT)) || (iter_q == CNT_W'(MAX_ITER)));
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done && !busy);
endmodule

// File: tb/sim_thresh_accum.sv
`timescale 1ns/1ps
module sim_thresh_accum;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [7:0] din = '0;
   logic [7:0] sum;
   logic       busy, done;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   thresh_accum u0 (
      .clk(clk), .rst(rst), .start(start), .din(din),
      .sum(sum), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pick(input int mode, input int idx);
      case (mode)
         0: pick = 8'($urandom_range(0, 255));
         1: pick = 8'($urandom_range(0, 7));
         2: pick = (idx == 0) ? 8'd42 : 8'd1;
         3: pick = 8'd0;
         4: pick = (idx == 0) ? 8'd40 : (idx == 1) ? 8'd250 : 8'd5;
         default: pick = 8'd3;
      endcase
   endfunction

   task automatic run_one(input int mode);
      int exp_sum = 0;
      int n = 0;
      bit ex = 0;
      @(negedge clk);
      start = 1'b1;
      din = 8'($urandom_range(0, 255));
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(sum == 8'd0, "R2 sum", sum, 0);
      while (!ex) begin
         din = pick(mode, n);
         start = 1'($urandom_range(0, 1));   // R8 start while busy
         @(posedge clk);
         exp_sum = (exp_sum + din) & 255;
         n++;
         @(negedge clk);
         ex = (exp_sum > 42) || (n == 255);
         chk(sum == 8'(exp_sum), "R3 sum", sum, exp_sum);
         if (ex) begin
            chk(done == 1'b1 && busy == 1'b1, "R4 done", done, 1);
            if (mode == 3) chk(n == 255, "R6 cap", n, 255);
         end else begin
            chk(done == 1'b0 && busy == 1'b1, "R8 busy", {busy, done}, 2);
            if (exp_sum == 42) chk(busy == 1'b1 && done == 1'b0, "R5 equal", done, 0);
         end
      end
      din = 8'($urandom_range(1, 255));
      start = 1'b1;   // R8 ignored in done cycle
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0 && busy == 1'b0, "R7 idle", {busy, done}, 0);
      chk(sum == 8'(exp_sum), "R7 held", sum, exp_sum);
      for (int i = 0; i < 3; i++) begin
         din = 8'($urandom_range(1, 255));
         @(posedge clk);
         @(negedge clk);
         chk(sum == 8'(exp_sum), "R9 idle", sum, exp_sum);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(sum == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 in reset", {sum, busy, done}, 0);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(sum == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 after", {sum, busy, done}, 0);
      run_one(2);
      run_one(3);
      run_one(4);
      for (int k = 0; k < 40; k++) run_one(k % 2);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule